// File: doc/BRIEF.md
# Variable-Latency Execute Cycle Scheduler

This block sets the timing of an in-order execute stage. Each operation that enters the stage carries a class code and a branch-condition code, and the current flag bits arrive with it. The scheduler turns these into a latency in clock cycles and loads that value into a down-counter. A conditional branch gets a different latency depending on whether its condition holds. While the counter is non-zero, a done signal tells the fetch and decode stages to hold. The computation the operation performs is handled elsewhere. The scheduler only decides how long the stage stays occupied.

An operation is taken in only when the counter is at zero. In the cycle it is taken, its latency is loaded and one cycle is counted off straight away, so a one-cycle operation leaves the counter at zero. The remaining cycle count is visible at the ports. An operation whose configured latency is zero would ask the counter to step down from zero. That sets a sticky internal-error flag. Accepting a HALT sets a sticky halted output, and from then on no operation is accepted until reset.

Top module: `exec_sched`

## Requirements
- R1: The latency for each class code is: 0 simple ALU = 1, 1 integer multiply/divide = 4, 2 float multiply/divide = 4, 3 memory/stack access = 2, 4 immediate load = 1, 7 call/return = 4, 8 sine/cosine = 4, 9 register move = 1, 10 NOP = 1. After the accepting edge, `cycles_left` equals the latency minus one.
- R2: Class 5 is a conditional branch. It costs 3 cycles when its condition holds and 1 cycle when it does not. Condition codes are 0 always, 1 zero (flags bit 0 set), 2 not-zero (bit 0 clear), 3 carry (flags bit 1 set) and 4 not-carry (bit 1 clear).
- R3: Class 6 is an unconditional branch. It costs 3 cycles whatever the condition code and flags are.
- R4: An operation is accepted only while `cycles_left` is zero. While the counter is non-zero, `op_valid` and the operation fields have no effect on `cycles_left`.
- R5: `exec_done` is 0 in every cycle where `cycles_left` is non-zero and 1 whenever it is zero. A one-cycle operation therefore never lowers it.
- R6: While the counter is non-zero, it decreases by exactly one on each clock edge.
- R7: Accepting an operation whose configured latency is zero sets `int_err`, which stays set until reset. The counter stays at zero.
- R8: Accepting a HALT (class 11, 1 cycle) sets `halted` until reset. While `halted` is set, valid operations are not accepted and `cycles_left` stays at 0.
- R9: After reset, `cycles_left` = 0, `exec_done` = 1, `halted` = 0 and `int_err` = 0.
- R10: Condition codes 5 to 7 never hold, so a conditional branch using them costs 1 cycle. Class codes 12 to 15 cost 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented |
| op_class | input | 4 | Operation class code |
| op_cond | input | 3 | Branch condition code |
| flags | input | 2 | Bit 0 zero, bit 1 carry |
| exec_done | output | 1 | High when the stage is free, low while counting |
| cycles_left | output | 8 | Remaining busy cycles |
| halted | output | 1 | Sticky halt state |
| int_err | output | 1 | Sticky decrement-from-zero error |

## Verification
The hardest state to reach from the ports is the internal error. With the default latency table, no class can ever ask the counter to step down from zero. The bench therefore adds a second instance whose NOP latency is set to zero and issues a NOP to it, then checks that the error is latched while the counter stays at zero. A second hard case is an operation held valid across a busy window with a different class: the counter must ignore it and keep counting down.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int CLS_W  = 4;
  localparam int COND_W = 3;
  localparam int FLAG_W = 2;
  localparam int FLAG_Z = 0;
  localparam int FLAG_C = 1;

  typedef enum logic [CLS_W-1:0] {
    CL_ALU     = 4'd0,
    CL_IMULDIV = 4'd1,
    CL_FMULDIV = 4'd2,
    CL_MEM     = 4'd3,
    CL_IMM     = 4'd4,
    CL_BRC     = 4'd5,
    CL_BRU     = 4'd6,
    CL_CALLRET = 4'd7,
    CL_TRIG    = 4'd8,
    CL_MOVE    = 4'd9,
    CL_NOP     = 4'd10,
    CL_HALT    = 4'd11
  } op_class_e;

  typedef enum logic [COND_W-1:0] {
    CD_ALWAYS = 3'd0,
    CD_ZERO   = 3'd1,
    CD_NZERO  = 3'd2,
    CD_CARRY  = 3'd3,
    CD_NCARRY = 3'd4
  } cond_e;
endpackage

// File: rtl/sched_cond.sv
module sched_cond
  import sched_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              hold_o
);
  always_comb begin
    case (cond_e'(cond_i))
      CD_ALWAYS: hold_o = 1'b1;
      CD_ZERO:   hold_o = flags_i[FLAG_Z];
      CD_NZERO:  hold_o = ~flags_i[FLAG_Z];
      CD_CARRY:  hold_o = flags_i[FLAG_C];
      CD_NCARRY: hold_o = ~flags_i[FLAG_C];
      default:   hold_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sched_lat.sv
module sched_lat
  import sched_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LAT_ALU   = 1,
  parameter int LAT_IMD   = 4,
  parameter int LAT_FMD   = 4,
  parameter int LAT_MEM   = 2,
  parameter int LAT_IMM   = 1,
  parameter int LAT_MOV   = 1,
  parameter int LAT_TRIG  = 4,
  parameter int LAT_CALL  = 4,
  parameter int LAT_BR_TK = 3,
  parameter int LAT_BR_NT = 1,
  parameter int LAT_BR_U  = 3,
  parameter int LAT_NOP   = 1,
  parameter int LAT_HALT  = 1,
  parameter int LAT_UNDEF = 1
) (
  input  logic [CLS_W-1:0] cls_i,
  input  logic             taken_i,
  output logic [CNT_W-1:0] lat_o
);
  always_comb begin
    case (op_class_e'(cls_i))
      CL_ALU:     lat_o = CNT_W'(LAT_ALU);
      CL_IMULDIV: lat_o = CNT_W'(LAT_IMD);
      CL_FMULDIV: lat_o = CNT_W'(LAT_FMD);
      CL_MEM:     lat_o = CNT_W'(LAT_MEM);
      CL_IMM:     lat_o = CNT_W'(LAT_IMM);
      CL_BRC:     lat_o = taken_i ? CNT_W'(LAT_BR_TK) : CNT_W'(LAT_BR_NT);
      CL_BRU:     lat_o = CNT_W'(LAT_BR_U);
      CL_CALLRET: lat_o = CNT_W'(LAT_CALL);
      CL_TRIG:    lat_o = CNT_W'(LAT_TRIG);
      CL_MOVE:    lat_o = CNT_W'(LAT_MOV);
      CL_NOP:     lat_o = CNT_W'(LAT_NOP);
      CL_HALT:    lat_o = CNT_W'(LAT_HALT);
      default:    lat_o = CNT_W'(LAT_UNDEF);
    endcase
  end
endmodule

// File: rtl/sched_ctr.sv
module sched_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    err_d  = err_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_en = 1'b1;
      if (load_val_i == '0) begin
        err_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = load_val_i - 1'b1;
      end
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
    done_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q  <= cnt_d;
        done_q <= done_d;
      end
      err_q <= err_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  AST_DONE_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done_q == (cnt_q == '0)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R7
  AST_ZERO_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i == '0) |=> (cnt_q == '0 && err_q)); // R7
endmodule

// File: rtl/exec_sched.sv
module exec_sched
  import sched_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LAT_ALU   = 1,
  parameter int LAT_IMD   = 4,
  parameter int LAT_FMD   = 4,
  parameter int LAT_MEM   = 2,
  parameter int LAT_IMM   = 1,
  parameter int LAT_MOV   = 1,
  parameter int LAT_TRIG  = 4,
  parameter int LAT_CALL  = 4,
  parameter int LAT_BR_TK = 3,
  parameter int LAT_BR_NT = 1,
  parameter int LAT_BR_U  = 3,
  parameter int LAT_NOP   = 1,
  parameter int LAT_HALT  = 1,
  parameter int LAT_UNDEF = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       op_class,
  input  logic [2:0]       op_cond,
  input  logic [1:0]       flags,
  output logic             exec_done,
  output logic [CNT_W-1:0] cycles_left,
  output logic             halted,
  output logic             int_err
);
  logic             cond_hold;
  logic [CNT_W-1:0] lat;
  logic             accept;
  logic             halted_q, halted_d;
  logic [CNT_W-1:0] cnt;
  logic             done;
  logic             err;

  sched_cond u_cond (
    .cond_i  (op_cond),
    .flags_i (flags),
    .hold_o  (cond_hold)
  );

  sched_lat #(
    .CNT_W(CNT_W), .LAT_ALU(LAT_ALU), .LAT_IMD(LAT_IMD), .LAT_FMD(LAT_FMD),
    .LAT_MEM(LAT_MEM), .LAT_IMM(LAT_IMM), .LAT_MOV(LAT_MOV),
    .LAT_TRIG(LAT_TRIG), .LAT_CALL(LAT_CALL), .LAT_BR_TK(LAT_BR_TK),
    .LAT_BR_NT(LAT_BR_NT), .LAT_BR_U(LAT_BR_U), .LAT_NOP(LAT_NOP),
    .LAT_HALT(LAT_HALT), .LAT_UNDEF(LAT_UNDEF)
  ) u_lat (
    .cls_i   (op_class),
    .taken_i (cond_hold),
    .lat_o   (lat)
  );

  assign accept = op_valid && !halted_q && (cnt == '0);

  sched_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_val_i (lat),
    .cnt_o      (cnt),
    .done_o     (done),
    .err_o      (err)
  );

  always_comb begin
    halted_d = halted_q;
    if (accept && op_class == CL_HALT) halted_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halted_q <= 1'b0;
    else        halted_q <= halted_d;
  end

  assign exec_done   = done;
  assign cycles_left = cnt;
  assign halted      = halted_q;
  assign int_err     = err;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R8
  AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && cycles_left == '0) |=> (cycles_left == '0)); // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (cycles_left > 8'd1) |=> (cycles_left != '0 && !exec_done)); // R4
  AST_UNCOND_COST: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !halted && cycles_left == '0 && op_class == CL_BRU)
      |=> (cycles_left == CNT_W'(LAT_BR_U - 1))); // R3
endmodule

// File: tb/sim_exec_sched.sv
module sim_exec_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_class = '0;
  logic [2:0] op_cond = '0;
  logic [1:0] flags = '0;
  logic       exec_done, halted, int_err;
  logic [7:0] cycles_left;

  logic       v1 = 1'b0;
  logic [3:0] c1 = '0;
  logic       done1, halt1, err1;
  logic [7:0] cnt1;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  exec_sched u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .op_cond(op_cond), .flags(flags), .exec_done(exec_done),
    .cycles_left(cycles_left), .halted(halted), .int_err(int_err)
  );

  exec_sched #(.LAT_NOP(0)) u1 (
    .clk(clk), .rst_n(rst_n), .op_valid(v1), .op_class(c1),
    .op_cond(3'd0), .flags(2'd0), .exec_done(done1),
    .cycles_left(cnt1), .halted(halt1), .int_err(err1)
  );

  // {class[15:12], cond[11:9], flags[8:7], latency[6:0]}
  localparam logic [15:0] VEC [22] = '{
    16'h0001, 16'h1004, 16'h2004, 16'h3002, 16'h4001, 16'h9001,
    16'h8004, 16'h7004, 16'hA001,
    16'h5283, 16'h5201, 16'h5403, 16'h5481, 16'h5703, 16'h5601,
    16'h5803, 16'h5901, 16'h5003, 16'h5B81,
    16'h6203, 16'hD001, 16'h0001
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    chk(cycles_left == 0, "R9 cycles_left", cycles_left, 0);
    chk(exec_done == 1'b1, "R9 exec_done", exec_done, 1);
    chk(halted == 1'b0, "R9 halted", halted, 0);
    chk(int_err == 1'b0, "R9 int_err", int_err, 0);

    // vector walk: R1, R2, R3, R10, R5, R6
    for (int i = 0; i < 22; i++) begin
      int lat;
      string tag;
      lat = int'(VEC[i][6:0]);
      if (VEC[i][15:12] >= 4'd12 || (VEC[i][15:12] == 4'd5 && VEC[i][11:9] >= 3'd5)) tag = "R10";
      else if (VEC[i][15:12] == 4'd5) tag = "R2";
      else if (VEC[i][15:12] == 4'd6) tag = "R3";
      else tag = "R1";
      op_class = VEC[i][15:12];
      op_cond  = VEC[i][11:9];
      flags    = VEC[i][8:7];
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      chk(cycles_left == 8'(lat - 1), tag, cycles_left, lat - 1);
      chk(exec_done == (lat == 1), "R5 done after accept", exec_done, (lat == 1));
      for (int k = lat - 1; k > 0; k--) begin
        @(negedge clk);
        chk(cycles_left == 8'(k - 1), "R6 countdown", cycles_left, k - 1);
      end
      chk(exec_done == 1'b1, "R5 done at zero", exec_done, 1);
    end

    // R4: valid held through busy window with another class
    op_class = 4'd1; op_cond = 3'd0; flags = 2'd0; op_valid = 1'b1;
    @(negedge clk);
    chk(cycles_left == 3, "R4 load", cycles_left, 3);
    op_class = 4'd8;
    @(negedge clk);
    chk(cycles_left == 2, "R4 busy ignore", cycles_left, 2);
    @(negedge clk);
    chk(cycles_left == 1, "R4 busy ignore", cycles_left, 1);
    chk(exec_done == 1'b0, "R5 low while busy", exec_done, 0);
    op_valid = 1'b0;
    @(negedge clk);
    chk(cycles_left == 0, "R4 end", cycles_left, 0);

    // R8: halt is sticky and blocks acceptance
    op_class = 4'd11; op_valid = 1'b1;
    @(negedge clk);
    chk(halted == 1'b1, "R8 halted set", halted, 1);
    chk(cycles_left == 0, "R8 halt cost", cycles_left, 0);
    op_class = 4'd1;
    @(negedge clk);
    @(negedge clk);
    chk(cycles_left == 0, "R8 blocked", cycles_left, 0);
    chk(exec_done == 1'b1, "R8 done while halted", exec_done, 1);
    chk(halted == 1'b1, "R8 sticky", halted, 1);
    op_valid = 1'b0;
    chk(int_err == 1'b0, "R7 no error on default table", int_err, 0);
    do_reset();
    chk(halted == 1'b0, "R9 halt cleared", halted, 0);

    // R7: zero-latency class on the second instance
    c1 = 4'd10; v1 = 1'b1;
    @(negedge clk);
    v1 = 1'b0;
    chk(err1 == 1'b1, "R7 error set", err1, 1);
    chk(cnt1 == 0, "R7 counter stays zero", cnt1, 0);
    @(negedge clk);
    chk(err1 == 1'b1, "R7 error sticky", err1, 1);
    chk(done1 == 1'b1, "R7 done stays high", done1, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule